// File: doc/BRIEF.md
# Address Translation Cache with Pinned Entries

This block holds a handful of recent virtual-page to physical-frame mappings so that most memory accesses skip the page table walk. Every lookup compares the requested virtual page number against all stored entries in parallel. On a hit, the frame number and the access rights (read, write, execute) come back combinationally in the same cycle. On a miss, a miss strobe tells the external walker to fetch the mapping. The walker later hands the mapping back through the insert port, and the block stores it.

Insertion first reuses an entry that already holds the same page. Failing that, it takes a free slot. Only when every slot is occupied does it evict the least recently used entry. Any entry may be pinned. A pinned entry is never picked for eviction, and it survives the flush strobe that software raises on a context switch. If every slot is valid and pinned, an insert has nowhere to go: it is dropped and a status output says so.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous reset, no entry is valid, every lookup misses, and lk_pfn and lk_perm read zero whenever lk_hit is low.
- R2: During a lookup cycle (lk_valid high), lk_hit, lk_pfn and lk_perm reflect the stored contents in that same cycle, and lk_miss equals lk_valid and not lk_hit. lk_perm bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: A performed insert is visible from the next cycle: a lookup of that page hits and returns the inserted frame and rights.
- R4: Inserting a page that is already stored overwrites that entry's frame, rights and pinned flag in place, so no page is ever held twice.
- R5: When there is no matching entry, an insert fills the lowest-numbered invalid entry and evicts nothing.
- R6: When all entries are valid and none matches, the insert replaces the least recently used unpinned entry. Use means a lookup hit or an insert of that entry.
- R7: A valid pinned entry is never replaced by an insert of a different page.
- R8: When an insert finds no matching entry, no invalid entry and no unpinned entry, ins_novictim is high in that cycle and the cache contents stay unchanged.
- R9: A flush clears every unpinned entry in one cycle and keeps the pinned ones. An insert in a flush cycle is ignored. A lookup in a flush cycle still sees the contents from before the flush.
- R10: A lookup and an insert of the same page in one cycle make the lookup report a miss while the insert proceeds. When a lookup hits in the same cycle as an insert, only the inserted entry is marked as used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Lookup found no mapping (walk needed) |
| lk_pfn | output | PFN_W | Frame number on a hit, else zero |
| lk_perm | output | 3 | Rights on a hit (bit0 read, bit1 write, bit2 execute), else zero |
| ins_valid | input | 1 | Mapping returned by the walker |
| ins_vpn | input | VPN_W | Page of the returned mapping |
| ins_pfn | input | PFN_W | Frame of the returned mapping |
| ins_perm | input | 3 | Rights of the returned mapping |
| ins_wired | input | 1 | Pin the entry against eviction and flush |
| ins_novictim | output | 1 | Insert dropped: all entries valid and pinned |
| flush | input | 1 | Context-switch invalidate of unpinned entries |

## Verification
The bench runs a timestamp-based model of recency and sweeps a pool of pages through the cache. Interleaved lookups reorder recency, so a design that evicted by insertion order, or that also counted a hit made in the same cycle as an insert, would lose the wrong page. Pinned inserts are sprinkled through the sweep, and the cache is later filled entirely with pinned pages. A design that evicted a pinned page, or that overwrote a slot when none was free, would show a missing page or a stray hit when every page is probed. Further cases cover a flush with an insert in the same cycle, a lookup and an insert of the same page in one cycle, and re-insertion of a stored page. These catch a dropped pinned entry, a stale hit, or a duplicate slot that would push out a live mapping.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  localparam int PERM_W = 3;  // bit0 read, bit1 write, bit2 execute

  typedef enum logic [1:0] {
    TGT_MATCH = 2'd0,  // overwrite entry holding same page
    TGT_FREE  = 2'd1,  // fill an invalid slot
    TGT_EVICT = 2'd2,  // replace LRU unpinned entry
    TGT_NONE  = 2'd3   // nowhere to place
  } tgt_kind_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] cand,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               victim_ok
);
  // age 0 = most recent; ages always form a permutation of 0..ENTRIES-1
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  logic [IDX_W-1:0] best_age;
  always_comb begin
    victim_ok  = 1'b0;
    victim_idx = '0;
    best_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cand[i] && (!victim_ok || age_q[i] > best_age)) begin
        victim_ok  = 1'b1;
        victim_idx = IDX_W'(i);
        best_age   = age_q[i];
      end
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              ins_valid,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic [PERM_W-1:0] ins_perm,
  input  logic              ins_wired,
  output logic              ins_novictim,
  input  logic              flush
);
  logic [ENTRIES-1:0]             valid_q, wired_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  logic [ENTRIES-1:0] lk_hit_vec, ins_hit_vec;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(vpn_q), .key(lk_vpn), .hit_vec(lk_hit_vec));
  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_ins_match (
    .valid(valid_q), .tags(vpn_q), .key(ins_vpn), .hit_vec(ins_hit_vec));

  // ---------------- lookup side ----------------
  logic              lk_block;
  logic [IDX_W-1:0]  lk_idx;
  logic [PFN_W-1:0]  lk_pfn_sel;
  logic [PERM_W-1:0] lk_perm_sel;

  assign lk_block = ins_valid && (ins_vpn == lk_vpn);
  assign lk_hit   = lk_valid && (|lk_hit_vec) && !lk_block;
  assign lk_miss  = lk_valid && !lk_hit;

  always_comb begin
    lk_idx      = '0;
    lk_pfn_sel  = '0;
    lk_perm_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) begin
        lk_idx      = IDX_W'(i);
        lk_pfn_sel  = lk_pfn_sel | pfn_q[i];
        lk_perm_sel = lk_perm_sel | perm_q[i];
      end
    end
  end

  assign lk_pfn  = lk_hit ? lk_pfn_sel  : '0;
  assign lk_perm = lk_hit ? lk_perm_sel : '0;

  // ---------------- insert side ----------------
  logic [IDX_W-1:0] match_idx, free_idx, victim_idx, tgt_idx;
  logic             free_any, victim_ok, ins_go, ins_do, touch_en;
  logic [IDX_W-1:0] touch_idx;
  tgt_kind_e        tgt_kind;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (ins_hit_vec[i]) match_idx = IDX_W'(i);
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
    .cand(valid_q & ~wired_q), .victim_idx(victim_idx), .victim_ok(victim_ok));

  always_comb begin
    if (|ins_hit_vec) begin
      tgt_kind = TGT_MATCH; tgt_idx = match_idx;
    end else if (free_any) begin
      tgt_kind = TGT_FREE;  tgt_idx = free_idx;
    end else if (victim_ok) begin
      tgt_kind = TGT_EVICT; tgt_idx = victim_idx;
    end else begin
      tgt_kind = TGT_NONE;  tgt_idx = '0;
    end
  end

  assign ins_go       = ins_valid && !flush;
  assign ins_novictim = ins_go && (tgt_kind == TGT_NONE);
  assign ins_do       = ins_go && (tgt_kind != TGT_NONE);
  assign touch_en     = ins_do || lk_hit;
  assign touch_idx    = ins_do ? tgt_idx : lk_idx;

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      wired_q <= '0;
    end else if (flush) begin
      valid_q <= valid_q & wired_q;
    end else if (ins_do) begin
      valid_q[tgt_idx] <= 1'b1;
      wired_q[tgt_idx] <= ins_wired;
    end
  end

  // payload carries no reset, so it can map onto plain storage
  always_ff @(posedge clk) begin
    if (ins_do) begin
      vpn_q[tgt_idx]  <= ins_vpn;
      pfn_q[tgt_idx]  <= ins_pfn;
      perm_q[tgt_idx] <= ins_perm;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 18
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           flush,
  input logic                           ins_valid,
  input logic [VPN_W-1:0]               ins_vpn,
  input logic [PFN_W-1:0]               ins_pfn,
  input logic                           ins_novictim,
  input logic                           lk_valid,
  input logic [VPN_W-1:0]               lk_vpn,
  input logic                           lk_hit,
  input logic [PFN_W-1:0]               lk_pfn,
  input logic [ENTRIES-1:0]             valid_q,
  input logic [ENTRIES-1:0]             wired_q,
  input logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q,
  input logic [ENTRIES-1:0]             lk_hit_vec
);
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> ((valid_q & ~wired_q) == '0));

  p_flush_keeps_pinned_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> ((valid_q & wired_q) == $past(valid_q & wired_q)));

  p_novictim_full_r8: assert property (@(posedge clk) disable iff (rst)
    ins_novictim |-> (&(valid_q & wired_q)));

  p_novictim_drop_r8: assert property (@(posedge clk) disable iff (rst)
    ins_novictim |=> (valid_q == $past(valid_q) && vpn_q == $past(vpn_q)));

  p_single_copy_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec));

  p_insert_visible_r3: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !flush && !ins_novictim) |=>
      (!(lk_valid && lk_vpn == $past(ins_vpn) && !(ins_valid && ins_vpn == lk_vpn))
       || (lk_hit && lk_pfn == $past(ins_pfn))));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pin
    p_pinned_kept_r7: assert property (@(posedge clk) disable iff (rst)
      (valid_q[g] && wired_q[g] && !flush) |=>
        (valid_q[g] && vpn_q[g] == $past(vpn_q[g])));
  end
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
  .ins_pfn(ins_pfn), .ins_novictim(ins_novictim), .lk_valid(lk_valid),
  .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .valid_q(valid_q),
  .wired_q(wired_q), .vpn_q(vpn_q), .lk_hit_vec(lk_hit_vec));

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int ENT = 8, VW = 20, PW = 18, POOL = 16;

  logic clk = 0, rst = 1;
  logic lk_valid = 0, ins_valid = 0, ins_wired = 0, flush = 0;
  logic [VW-1:0] lk_vpn = '0, ins_vpn = '0;
  logic [PW-1:0] ins_pfn = '0;
  logic [2:0] ins_perm = '0;
  logic lk_hit, lk_miss, ins_novictim;
  logic [PW-1:0] lk_pfn;
  logic [2:0] lk_perm;

  always #2 clk = ~clk;  // 250 MHz

  xlat_cache #(.ENTRIES(ENT), .VPN_W(VW), .PFN_W(PW)) u_xlat_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_perm(lk_perm), .ins_valid(ins_valid),
    .ins_vpn(ins_vpn), .ins_pfn(ins_pfn), .ins_perm(ins_perm), .ins_wired(ins_wired),
    .ins_novictim(ins_novictim), .flush(flush));

  int n_chk = 0, n_bad = 0, tnow = 0;
  bit done = 0;

  // recency model: per-slot last-use timestamps
  bit          m_valid[ENT], m_wired[ENT];
  int          m_vpn[ENT], m_pfn[ENT], m_perm[ENT], m_last[ENT];

  function automatic logic [VW-1:0] pool(int k);
    return VW'(32'h100 + k * 37);
  endfunction

  function automatic int m_find(int vpn);
    for (int i = 0; i < ENT; i++) if (m_valid[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int m_target(int vpn);
    int best = -1;
    if (m_find(vpn) >= 0) return m_find(vpn);
    for (int i = 0; i < ENT; i++) if (!m_valid[i]) return i;
    for (int i = 0; i < ENT; i++)
      if (!m_wired[i] && (best < 0 || m_last[i] < m_last[best])) best = i;
    return best;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(bit lv, logic [VW-1:0] lvpn, bit iv, logic [VW-1:0] ivpn,
                    int ipfn, int iperm, bit iw, bit fl, string req);
    int idx, tgt;
    bit ehit, ego, enov;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn; ins_valid = iv; ins_vpn = ivpn;
    ins_pfn = PW'(ipfn); ins_perm = 3'(iperm); ins_wired = iw; flush = fl;
    #1;
    idx  = m_find(int'(lvpn));
    ehit = lv && idx >= 0 && !(iv && ivpn == lvpn);
    if (lv) begin
      check(lk_hit == ehit, {req, " hit"}, int'(lk_hit), int'(ehit));
      check(lk_miss == !ehit, {req, " miss (R2)"}, int'(lk_miss), int'(!ehit));
      check(int'(lk_pfn) == (ehit ? m_pfn[idx] : 0), {req, " frame"}, int'(lk_pfn),
            ehit ? m_pfn[idx] : 0);
      check(int'(lk_perm) == (ehit ? m_perm[idx] : 0), {req, " rights"}, int'(lk_perm),
            ehit ? m_perm[idx] : 0);
    end
    ego  = iv && !fl;
    tgt  = m_target(int'(ivpn));
    enov = ego && tgt < 0;
    if (iv) check(ins_novictim == enov, {req, " novictim"}, int'(ins_novictim), int'(enov));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < ENT; i++) if (!m_wired[i]) m_valid[i] = 0;
    end
    if (ego && !enov) begin
      m_valid[tgt] = 1; m_wired[tgt] = iw; m_vpn[tgt] = int'(ivpn);
      m_pfn[tgt] = ipfn % (1 << PW); m_perm[tgt] = iperm % 8; m_last[tgt] = tnow;
    end else if (ehit) begin
      m_last[idx] = tnow;
    end
    tnow++;
  endtask

  task automatic probe_all(string req);
    for (int k = 0; k < POOL; k++) op(1, pool(k), 0, '0, 0, 0, 0, 0, req);
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin
      m_valid[i] = 0; m_wired[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
      m_last[i] = -1 - i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: empty after reset
    op(1, pool(0), 0, '0, 0, 0, 0, 0, "R1");
    op(1, pool(5), 0, '0, 0, 0, 0, 0, "R1");
    // R5: fill free slots in order, R3/R2 visibility
    for (int k = 0; k < ENT; k++) begin
      op(0, '0, 1, pool(k), k * 1000 + 5, k, 0, 0, "R5");
      op(1, pool(k), 0, '0, 0, 0, 0, 0, "R3");
    end
    probe_all("R2");
    // R4: re-insert stored page
    op(0, '0, 1, pool(3), 777, 6, 0, 0, "R4");
    probe_all("R4");
    // R6/R7/R10: recency sweep with pins and same-cycle pairs
    for (int r = 0; r < 30; r++) begin
      op(1, pool((r * 5) % POOL), 0, '0, 0, 0, 0, 0, "R6");
      op(1, pool((r * 3 + 1) % POOL), 0, '0, 0, 0, 0, 0, "R6");
      op(0, '0, 1, pool((r * 7 + 2) % POOL), r * 11 + 3, r, (r % 9) == 4, 0, "R7");
      op(1, pool(r % POOL), 1, pool((r + 9) % POOL), r * 13 + 1, r + 2, 0, 0, "R10");
      op(1, pool((r * 11) % POOL), 1, pool((r * 11) % POOL), r * 17, r + 1, 0, 0, "R10");
      if (r % 6 == 5) probe_all("R6");
    end
    // R9: flush with concurrent insert and lookup
    op(1, pool(2), 1, pool(15), 4242, 7, 0, 1, "R9");
    probe_all("R9");
    // R8: fill with pinned pages, then overflow
    for (int k = 0; k < POOL; k++) op(0, '0, 1, pool(k), k + 900, k, 1, 0, "R7");
    probe_all("R7");
    op(0, '0, 1, VW'(20'hABCDE), 55, 1, 0, 0, "R8");
    op(1, VW'(20'hABCDE), 0, '0, 0, 0, 0, 0, "R8");
    op(0, '0, 1, VW'(20'h12345), 56, 2, 1, 0, "R8");
    probe_all("R8");
    op(0, '0, 0, '0, 0, 0, 0, 1, "R9");
    probe_all("R9");
    @(negedge clk);
    lk_valid = 0; ins_valid = 0; flush = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule